// File: doc/BRIEF.md
# Exception Entry and Saved-PC Selector

This block is the control point through which a simple in-order 32-bit processor enters and leaves exception and interrupt handling. Each cycle it samples a soft-reset request, a general exception request (flagged as re-executing or completed), a non-maskable interrupt, a leveled maskable interrupt and a return-from-exception request. It picks one of them by fixed priority and then acts on the choice.

For an accepted entry it works out the program counter to save. It uses the faulting, following, delayed-branch and branch-target addresses, together with the delay-slot and branch-outcome flags. It copies the status register into the saved-status register, raises the mode, block and bank bits, and issues a one-cycle redirect to a handler address relative to the vector base. A request that arrives while the block bit is set either falls back to the reset address or waits, depending on its kind. Sleep and a mask override open two exceptions to that rule.

All results are registered. A request sampled at one rising edge is visible on the outputs after that edge.

Top module: `exc_entry`

## Requirements
- R1: While `rst_n` is low the status register holds md=1, bl=1, rb=1, imask=4'hF. The vector base, saved PC and saved status are zero, `redirect_pc` is 0xA0000000 and `redirect_valid` is 0.
- R2: A `rst_req` sampled at an edge produces, after that edge, a redirect to 0xA0000000 with the status register at its R1 values and the vector base at zero. Saved PC and saved status keep their old values.
- R3: For an accepted exception with `exc_reexec`=1, the saved PC is `pc_dbr` when `in_dslot`=1 and `pc_cur` otherwise.
- R4: For an accepted completed exception (`exc_reexec`=0) or any accepted interrupt, the saved PC is chosen by the branch flags. With `br_cause`=1 it is `pc_tgt` if `br_taken`=1 and `pc_next` if `br_taken`=0. With `br_cause`=0 it is `pc_next`.
- R5: On a normal entry, the saved status receives the old status packed as {md,bl,rb,imask}, and md, bl and rb become 1. Exceptions redirect to vector base + 0x100 and interrupts to vector base + 0x600, using the vector base from before the edge. A maskable interrupt also loads imask with its level. Other entries leave imask unchanged.
- R6: A general exception requested while bl=1 behaves as R2. It redirects to 0xA0000000 and leaves saved PC and saved status unchanged.
- R7: A maskable interrupt is taken only if `irq_level` > imask and either bl=0 or `sleeping`=1. Otherwise nothing changes and no redirect occurs.
- R8: A non-maskable interrupt is taken when bl=0 or `blk_ovr`=1. Otherwise it has no effect.
- R9: Priority, from highest to lowest: `rst_req`, exception under bl=1, non-maskable interrupt, other exception, maskable interrupt, return from exception.
- R10: An accepted `rte_req` copies the saved status into the status register and redirects to the saved PC.
- R11: `vbr_wr` loads `vbr_wdata` into the vector base at the edge, unless a reset-type action (R2 or R6) happens in the same cycle, which clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Soft reset request |
| exc_req | input | 1 | General exception request |
| exc_reexec | input | 1 | 1 = re-executing exception, 0 = completed |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_level | input | 4 | Level of the maskable interrupt |
| rte_req | input | 1 | Return from exception |
| blk_ovr | input | 1 | Lets NMI through while bl=1 |
| sleeping | input | 1 | Core is in sleep or standby |
| pc_cur | input | 32 | Address of the faulting instruction |
| pc_next | input | 32 | Address of the next sequential instruction / delay slot |
| pc_dbr | input | 32 | Address of the delayed branch before a delay slot |
| pc_tgt | input | 32 | Branch destination |
| in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| br_cause | input | 1 | Cause is a conditional delayed branch |
| br_taken | input | 1 | Condition of that branch held |
| vbr_wr | input | 1 | Vector base write strobe |
| vbr_wdata | input | 32 | Vector base write data |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Redirect address |
| sr_md | output | 1 | Status: privileged mode |
| sr_bl | output | 1 | Status: block bit |
| sr_rb | output | 1 | Status: register bank |
| sr_imask | output | 4 | Status: interrupt mask |
| spc | output | 32 | Saved PC |
| ssr | output | 7 | Saved status {md,bl,rb,imask} |
| vbr | output | 32 | Vector base |

## Verification
Every piece of state in this block reaches a port. If the status, saved-PC, saved-status or vector-base register is wrong, the mismatch shows directly on `sr_*`, `spc`, `ssr` or `vbr` one edge after the faulty update. An arbitration fault, such as a wrong winner, a missed block rule or a missed sleep exception, shows in the same cycle as a wrong `redirect_valid` or `redirect_pc`. A corrupted saved status that is not read at once becomes visible no later than the next accepted return, when it is copied back into the status register. The bench compares all of these outputs against a behavioural model on every cycle, so each such fault is reported at the first edge where it appears.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int IMW = 4;

    typedef struct packed {
        logic           md;
        logic           bl;
        logic           rb;
        logic [IMW-1:0] imask;
    } sr_t;

    localparam int SRW = $bits(sr_t);

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_BLKRST,
        ACT_NMI,
        ACT_EXC,
        ACT_IRQ,
        ACT_RTE
    } act_e;

    localparam sr_t SR_RESET = '{md: 1'b1, bl: 1'b1, rb: 1'b1, imask: {IMW{1'b1}}};

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic           rst_req,
    input  logic           exc_req,
    input  logic           nmi_req,
    input  logic           irq_req,
    input  logic [IMW-1:0] irq_level,
    input  logic           rte_req,
    input  logic           blk_ovr,
    input  logic           sleeping,
    input  sr_t            sr,
    output act_e           act
);
    logic nmi_ok;
    logic irq_ok;

    always_comb begin
        nmi_ok = nmi_req && (!sr.bl || blk_ovr);
        irq_ok = irq_req && (irq_level > sr.imask) && (!sr.bl || sleeping);

        if (rst_req)                act = ACT_RESET;
        else if (exc_req && sr.bl)  act = ACT_BLKRST;
        else if (nmi_ok)            act = ACT_NMI;
        else if (exc_req)           act = ACT_EXC;
        else if (irq_ok)            act = ACT_IRQ;
        else if (rte_req)           act = ACT_RTE;
        else                        act = ACT_NONE;
    end
endmodule

// File: rtl/exc_savepc.sv
module exc_savepc #(
    parameter int XLEN = 32
) (
    input  logic            is_exc,
    input  logic            exc_reexec,
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] pc_next,
    input  logic [XLEN-1:0] pc_dbr,
    input  logic [XLEN-1:0] pc_tgt,
    input  logic            in_dslot,
    input  logic            br_cause,
    input  logic            br_taken,
    output logic [XLEN-1:0] saved_pc
);
    logic [XLEN-1:0] reexec_pc;
    logic [XLEN-1:0] done_pc;

    always_comb begin
        reexec_pc = in_dslot ? pc_dbr : pc_cur;
        if (br_cause && br_taken) done_pc = pc_tgt;
        else                      done_pc = pc_next;
        saved_pc = (is_exc && exc_reexec) ? reexec_pc : done_pc;
    end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
    parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
    parameter logic [XLEN-1:0] INT_OFS   = 32'h0000_0600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic            exc_req,
    input  logic            exc_reexec,
    input  logic            nmi_req,
    input  logic            irq_req,
    input  logic [IMW-1:0]  irq_level,
    input  logic            rte_req,
    input  logic            blk_ovr,
    input  logic            sleeping,
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] pc_next,
    input  logic [XLEN-1:0] pc_dbr,
    input  logic [XLEN-1:0] pc_tgt,
    input  logic            in_dslot,
    input  logic            br_cause,
    input  logic            br_taken,
    input  logic            vbr_wr,
    input  logic [XLEN-1:0] vbr_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            sr_md,
    output logic            sr_bl,
    output logic            sr_rb,
    output logic [IMW-1:0]  sr_imask,
    output logic [XLEN-1:0] spc,
    output logic [SRW-1:0]  ssr,
    output logic [XLEN-1:0] vbr
);
    typedef struct packed {
        sr_t             sr;
        sr_t             ssr;
        logic [XLEN-1:0] spc;
        logic [XLEN-1:0] vbr;
        logic [XLEN-1:0] rpc;
        logic            rvld;
    } state_t;

    state_t          st_d, st_q;
    act_e            act;
    logic [XLEN-1:0] saved_pc;

    exc_arbiter u_arb (
        .rst_req   (rst_req),
        .exc_req   (exc_req),
        .nmi_req   (nmi_req),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .rte_req   (rte_req),
        .blk_ovr   (blk_ovr),
        .sleeping  (sleeping),
        .sr        (st_q.sr),
        .act       (act)
    );

    exc_savepc #(.XLEN(XLEN)) u_spc (
        .is_exc     (act == ACT_EXC),
        .exc_reexec (exc_reexec),
        .pc_cur     (pc_cur),
        .pc_next    (pc_next),
        .pc_dbr     (pc_dbr),
        .pc_tgt     (pc_tgt),
        .in_dslot   (in_dslot),
        .br_cause   (br_cause),
        .br_taken   (br_taken),
        .saved_pc   (saved_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        if (vbr_wr) st_d.vbr = vbr_wdata;

        case (act)
            ACT_RESET, ACT_BLKRST: begin
                st_d.sr   = SR_RESET;
                st_d.vbr  = '0;
                st_d.rpc  = RESET_VEC;
                st_d.rvld = 1'b1;
            end
            ACT_NMI, ACT_EXC, ACT_IRQ: begin
                st_d.ssr   = st_q.sr;
                st_d.spc   = saved_pc;
                st_d.sr.md = 1'b1;
                st_d.sr.bl = 1'b1;
                st_d.sr.rb = 1'b1;
                if (act == ACT_IRQ) st_d.sr.imask = irq_level;
                st_d.rpc  = st_q.vbr + ((act == ACT_EXC) ? GEN_OFS : INT_OFS);
                st_d.rvld = 1'b1;
            end
            ACT_RTE: begin
                st_d.sr   = st_q.ssr;
                st_d.rpc  = st_q.spc;
                st_d.rvld = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sr   <= SR_RESET;
            st_q.rpc  <= RESET_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.rvld;
    assign redirect_pc    = st_q.rpc;
    assign sr_md          = st_q.sr.md;
    assign sr_bl          = st_q.sr.bl;
    assign sr_rb          = st_q.sr.rb;
    assign sr_imask       = st_q.sr.imask;
    assign spc            = st_q.spc;
    assign ssr            = st_q.ssr;
    assign vbr            = st_q.vbr;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
    parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
    parameter logic [XLEN-1:0] INT_OFS   = 32'h0000_0600
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req,
    input logic            exc_req,
    input logic            exc_reexec,
    input logic            nmi_req,
    input logic            irq_req,
    input logic            rte_req,
    input logic            blk_ovr,
    input logic            sleeping,
    input logic [XLEN-1:0] pc_cur,
    input logic [XLEN-1:0] pc_dbr,
    input logic            in_dslot,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            sr_md,
    input logic            sr_bl,
    input logic            sr_rb,
    input logic [IMW-1:0]  sr_imask,
    input logic [XLEN-1:0] spc,
    input logic [SRW-1:0]  ssr,
    input logic [XLEN-1:0] vbr
);
    p_softrst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> redirect_valid && redirect_pc == RESET_VEC && sr_bl && sr_md
                    && vbr == '0 && $stable(spc) && $stable(ssr));

    p_blkexc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && sr_bl && !rst_req) |=> redirect_valid && redirect_pc == RESET_VEC
                    && $stable(spc) && $stable(ssr));

    p_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !sr_bl && !rst_req && !nmi_req) |=> sr_bl && sr_md && sr_rb
                    && ssr == $past({sr_md, sr_bl, sr_rb, sr_imask})
                    && redirect_pc == $past(vbr) + GEN_OFS);

    p_reexec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_reexec && !sr_bl && !rst_req && !nmi_req)
                    |=> spc == $past(in_dslot ? pc_dbr : pc_cur));

    p_irqhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && sr_bl && !sleeping && !rst_req && !exc_req && !nmi_req && !rte_req)
                    |=> !redirect_valid && $stable(spc) && $stable(sr_imask));

    p_nmiovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && blk_ovr && !rst_req && !(exc_req && sr_bl))
                    |=> redirect_valid && redirect_pc == $past(vbr) + INT_OFS);

    p_rte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && !rst_req && !exc_req && !nmi_req && !irq_req)
                    |=> {sr_md, sr_bl, sr_rb, sr_imask} == $past(ssr)
                    && redirect_valid && redirect_pc == $past(spc));
endmodule

bind exc_entry exc_entry_chk #(
    .XLEN(XLEN), .RESET_VEC(RESET_VEC), .GEN_OFS(GEN_OFS), .INT_OFS(INT_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .exc_req(exc_req),
    .exc_reexec(exc_reexec), .nmi_req(nmi_req), .irq_req(irq_req),
    .rte_req(rte_req), .blk_ovr(blk_ovr), .sleeping(sleeping),
    .pc_cur(pc_cur), .pc_dbr(pc_dbr), .in_dslot(in_dslot),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .sr_md(sr_md), .sr_bl(sr_bl), .sr_rb(sr_rb), .sr_imask(sr_imask),
    .spc(spc), .ssr(ssr), .vbr(vbr)
);

// File: tb/exc_entry_tb.sv
`timescale 1ns/1ps
module exc_entry_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req, exc_req, exc_reexec, nmi_req, irq_req, rte_req;
    logic [3:0]  irq_level;
    logic        blk_ovr, sleeping, in_dslot, br_cause, br_taken, vbr_wr;
    logic [31:0] pc_cur, pc_next, pc_dbr, pc_tgt, vbr_wdata;
    logic        redirect_valid, sr_md, sr_bl, sr_rb;
    logic [31:0] redirect_pc, spc, vbr;
    logic [3:0]  sr_imask;
    logic [6:0]  ssr;

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R1";

    // reference state, status packed {md,bl,rb,imask}
    logic [6:0]  m_sr, m_ssr;
    logic [31:0] m_spc, m_vbr, m_rpc;
    logic        m_rv;

    always #2.5 clk = ~clk;

    exc_entry u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .exc_req(exc_req),
        .exc_reexec(exc_reexec), .nmi_req(nmi_req), .irq_req(irq_req),
        .irq_level(irq_level), .rte_req(rte_req), .blk_ovr(blk_ovr),
        .sleeping(sleeping), .pc_cur(pc_cur), .pc_next(pc_next),
        .pc_dbr(pc_dbr), .pc_tgt(pc_tgt), .in_dslot(in_dslot),
        .br_cause(br_cause), .br_taken(br_taken), .vbr_wr(vbr_wr),
        .vbr_wdata(vbr_wdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .sr_md(sr_md), .sr_bl(sr_bl),
        .sr_rb(sr_rb), .sr_imask(sr_imask), .spc(spc), .ssr(ssr), .vbr(vbr)
    );

    // behavioural reference, one decision per cycle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sr <= 7'h7F; m_ssr <= 0; m_spc <= 0; m_vbr <= 0;
            m_rpc <= 32'hA000_0000; m_rv <= 0;
        end else begin
            bit blk, took;
            logic [31:0] follow, vb;
            blk    = m_sr[5];
            follow = (br_cause && br_taken) ? pc_tgt : pc_next;
            vb     = vbr_wr ? vbr_wdata : m_vbr;
            took   = 1;
            if (rst_req || (exc_req && blk)) begin
                m_sr <= 7'h7F; vb = 0; m_rpc <= 32'hA000_0000;
            end else if (nmi_req && (!blk || blk_ovr)) begin
                m_ssr <= m_sr; m_spc <= follow; m_sr <= m_sr | 7'h70;
                m_rpc <= m_vbr + 32'h600;
            end else if (exc_req) begin
                m_ssr <= m_sr; m_sr <= m_sr | 7'h70;
                m_spc <= exc_reexec ? (in_dslot ? pc_dbr : pc_cur) : follow;
                m_rpc <= m_vbr + 32'h100;
            end else if (irq_req && irq_level > m_sr[3:0] && (!blk || sleeping)) begin
                m_ssr <= m_sr; m_spc <= follow; m_sr <= {3'b111, irq_level};
                m_rpc <= m_vbr + 32'h600;
            end else if (rte_req) begin
                m_sr <= m_ssr; m_rpc <= m_spc;
            end else took = 0;
            m_rv  <= took;
            m_vbr <= vb;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
        chk("redirect_pc", redirect_pc, m_rpc);
        chk("sr", {25'b0, sr_md, sr_bl, sr_rb, sr_imask}, {25'b0, m_sr});
        chk("ssr", {25'b0, ssr}, {25'b0, m_ssr});
        chk("spc", spc, m_spc);
        chk("vbr", vbr, m_vbr);
    end

    task automatic idle();
        rst_req = 0; exc_req = 0; exc_reexec = 0; nmi_req = 0; irq_req = 0;
        rte_req = 0; irq_level = 0; blk_ovr = 0; sleeping = 0; in_dslot = 0;
        br_cause = 0; br_taken = 0; vbr_wr = 0; vbr_wdata = 0;
        pc_cur = 32'h0000_1000; pc_next = 32'h0000_1002;
        pc_dbr = 32'h0000_0FFE; pc_tgt = 32'h0000_2000;
    endtask

    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    task automatic do_rte(); rte_req = 1; tick(); endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        #12 rst_n = 1;
        @(posedge clk); #1;
        tag = "R1"; tick(); tick();
        tag = "R6"; exc_req = 1; exc_reexec = 1; tick(); tick();
        tag = "R10"; do_rte(); tick();
        tag = "R11"; vbr_wr = 1; vbr_wdata = 32'h8000_0000; tick(); tick();
        tag = "R3"; exc_req = 1; exc_reexec = 1; tick(); tag = "R10"; do_rte();
        tag = "R3"; exc_req = 1; exc_reexec = 1; in_dslot = 1; tick(); do_rte();
        tag = "R4"; exc_req = 1; br_cause = 1; br_taken = 1; tick(); do_rte();
        tag = "R4"; exc_req = 1; br_cause = 1; br_taken = 0; tick(); do_rte();
        tag = "R4"; exc_req = 1; tick(); do_rte();
        tag = "R5"; irq_req = 1; irq_level = 5; br_cause = 1; br_taken = 1; tick(); tick();
        tag = "R7"; irq_req = 1; irq_level = 7; tick(); tick();
        tag = "R7"; irq_req = 1; irq_level = 5; sleeping = 1; tick(); tick();
        tag = "R7"; irq_req = 1; irq_level = 6; sleeping = 1; tick(); tick();
        tag = "R8"; nmi_req = 1; tick(); tick();
        tag = "R8"; nmi_req = 1; blk_ovr = 1; tick(); tick();
        tag = "R10"; do_rte(); do_rte(); do_rte();
        tag = "R9"; rst_req = 1; exc_req = 1; nmi_req = 1; tick();
        tag = "R9"; nmi_req = 1; blk_ovr = 1; exc_req = 1; tick();
        tag = "R2"; vbr_wr = 1; vbr_wdata = 32'h4000_0000; rst_req = 1; tick(); tick();
        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            rst_req    = ($urandom_range(0, 40) == 0);
            exc_req    = ($urandom_range(0, 5) == 0);
            exc_reexec = $urandom_range(0, 1);
            nmi_req    = ($urandom_range(0, 7) == 0);
            irq_req    = $urandom_range(0, 1);
            irq_level  = 4'($urandom_range(0, 15));
            rte_req    = ($urandom_range(0, 2) == 0);
            blk_ovr    = $urandom_range(0, 1);
            sleeping   = $urandom_range(0, 1);
            in_dslot   = $urandom_range(0, 1);
            br_cause   = $urandom_range(0, 1);
            br_taken   = $urandom_range(0, 1);
            vbr_wr     = ($urandom_range(0, 9) == 0);
            vbr_wdata  = $urandom & 32'hFFFF_F000;
            pc_cur     = $urandom; pc_next = $urandom;
            pc_dbr     = $urandom; pc_tgt  = $urandom;
            @(posedge clk); #1;
        end
        idle(); tick(); tick();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule